// File: doc/BRIEF.md
# Dual Glitch-Free Clock Output Divider

This block divides one fast source clock into two slower clock outputs. Each of two integer dividers has its own ratio input. Output 0 always follows divider 0. Output 1 follows either divider 0 or divider 1, as chosen by a select input. A ratio can be changed while the block is running. The output lets its current period run to the end and starts the new period on the next rising edge, so no runt pulse appears. After reset both dividers begin their first period on the same source edge, so their rising edges coincide wherever the two periods meet.

Three controls act on the outputs. A global force-low input holds both clock levels low. A per-output enable drives an output-enable pin that a pad driver uses to tri-state that output. The output-enable pins ignore force-low, so a disabled output stays in high impedance while force-low is set. Every output, level and enable, comes from a register clocked by the source clock.

Top module: `dual_clkdiv`

## Requirements
- R1: While `rst_n` is low, `clk_out0`, `clk_out1`, `clk_out0_oe` and `clk_out1_oe` are all 0.
- R2: With a ratio N of 2 or more, a divider repeats a period of N source cycles. It is high for the first floor(N/2) cycles and low for the rest.
- R3: A ratio input of 0 or 1 behaves exactly like a ratio of 2.
- R4: A divider samples its ratio input only on the last cycle of a period. A change made mid-period does not alter that period, and the new period starts with a rising edge.
- R5: On the first source edge after reset release, both dividers rise together. With equal ratios from reset, the two outputs are identical.
- R6: `clk_out0` follows divider 0 only, whatever the value of `out1_src_sel`.
- R7: `out1_src_sel` (0 = divider 0, 1 = divider 1) is acted on at the end of the current source's period. If the new divider is not also at its period end, `clk_out1` stays low until the new divider's next rising edge.
- R8: When `force_low` is sampled high on an edge, both clock outputs are low after that edge. They follow their dividers again once it is low.
- R9: After each edge, `clk_out0_oe` and `clk_out1_oe` equal `out0_en` and `out1_en` as sampled on that edge.
- R10: `force_low` has no effect on `clk_out0_oe` or `clk_out1_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div0_ratio | input | RATIO_W | Divide ratio for divider 0 |
| div1_ratio | input | RATIO_W | Divide ratio for divider 1 |
| out1_src_sel | input | 1 | Source of output 1: 0 = divider 0, 1 = divider 1 |
| force_low | input | 1 | Forces both clock levels low |
| out0_en | input | 1 | Enable for output 0 |
| out1_en | input | 1 | Enable for output 1 |
| clk_out0 | output | 1 | Divided clock level, output 0 |
| clk_out0_oe | output | 1 | Pad output enable for output 0 (0 = high impedance) |
| clk_out1 | output | 1 | Divided clock level, output 1 |
| clk_out1_oe | output | 1 | Pad output enable for output 1 (0 = high impedance) |

## Verification
A corrupted position counter or stored ratio in a divider shows up at the ports within one period, as a rising edge in the wrong cycle or a high phase of the wrong length. A bad switch state for output 1 shows up as a high level or a rising edge that does not match the chosen divider, within one period of the slower divider. The reference model tracks each divider's position and the select hand-over as plain integers. It compares every output on every source cycle, so any such fault is reported in the cycle where it first reaches a pin.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    SRC_DIV0 = 1'b0,
    SRC_DIV1 = 1'b1
  } src_e;

  localparam int NUM_DIV = 2;

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_req,
  output logic               wrap,
  output logic               hi_nxt
);

  localparam logic [RATIO_W-1:0] PER_MIN = RATIO_W'(2);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] per_q, per_d;
  logic [RATIO_W-1:0] per_eff;
  logic               start_q;

  // next-state
  always_comb begin
    per_eff = (ratio_req < PER_MIN) ? PER_MIN : ratio_req;
    wrap    = start_q | (cnt_q == (per_q - RATIO_W'(1)));
    cnt_d   = wrap ? '0 : (cnt_q + RATIO_W'(1));
    per_d   = wrap ? per_eff : per_q;
    hi_nxt  = (cnt_d < (per_d >> 1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= PER_MIN;
      start_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      start_q <= 1'b0;
    end
  end

endmodule

// File: rtl/clkdiv_srcsel.sv
module clkdiv_srcsel
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_req,
  input  logic [NUM_DIV-1:0] wrap,
  input  logic [NUM_DIV-1:0] hi_nxt,
  output logic               lvl_nxt
);

  src_e sel_q, sel_d;
  logic hold_q, hold_d;
  logic cur_idx, new_idx;

  // next-state
  always_comb begin
    sel_d   = sel_q;
    hold_d  = hold_q;
    cur_idx = (sel_q == SRC_DIV1);
    if (hold_q) begin
      if (wrap[cur_idx]) hold_d = 1'b0;
    end else if ((sel_req != cur_idx) && wrap[cur_idx]) begin
      sel_d  = sel_req ? SRC_DIV1 : SRC_DIV0;
      hold_d = !wrap[sel_req];
    end
    new_idx = (sel_d == SRC_DIV1);
    lvl_nxt = !hold_d && hi_nxt[new_idx];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SRC_DIV0;
      hold_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/dual_clkdiv.sv
module dual_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] div0_ratio,
  input  logic [RATIO_W-1:0] div1_ratio,
  input  logic               out1_src_sel,
  input  logic               force_low,
  input  logic               out0_en,
  input  logic               out1_en,
  output logic               clk_out0,
  output logic               clk_out0_oe,
  output logic               clk_out1,
  output logic               clk_out1_oe
);

  logic [RATIO_W-1:0] ratio_req [NUM_DIV];
  logic [NUM_DIV-1:0] div_wrap;
  logic [NUM_DIV-1:0] div_hi_nxt;
  logic               out1_lvl_nxt;

  logic [NUM_DIV-1:0] lvl_q, lvl_d;
  logic [NUM_DIV-1:0] oe_q, oe_d;

  assign ratio_req[0] = div0_ratio;
  assign ratio_req[1] = div1_ratio;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    clkdiv_counter #(.RATIO_W(RATIO_W)) u_div (
      .clk       (clk_src),
      .rst_n     (rst_n),
      .ratio_req (ratio_req[i]),
      .wrap      (div_wrap[i]),
      .hi_nxt    (div_hi_nxt[i])
    );
  end

  clkdiv_srcsel u_sel (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .sel_req (out1_src_sel),
    .wrap    (div_wrap),
    .hi_nxt  (div_hi_nxt),
    .lvl_nxt (out1_lvl_nxt)
  );

  // next-state
  always_comb begin
    lvl_d[0] = div_hi_nxt[0] & ~force_low;
    lvl_d[1] = out1_lvl_nxt  & ~force_low;
    oe_d     = {out1_en, out0_en};
  end

  // registers
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      oe_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      oe_q  <= oe_d;
    end
  end

  assign clk_out0    = lvl_q[0];
  assign clk_out1    = lvl_q[1];
  assign clk_out0_oe = oe_q[0];
  assign clk_out1_oe = oe_q[1];

endmodule

// File: rtl/dual_clkdiv_checker.sv
module dual_clkdiv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       force_low,
  input logic       out0_en,
  input logic       out1_en,
  input logic [1:0] div_wrap,
  input logic       clk_out0,
  input logic       clk_out1,
  input logic       clk_out0_oe,
  input logic       clk_out1_oe
);

  assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> (!clk_out0 && !clk_out1));

  assert_oe_follows_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((clk_out0_oe == $past(out0_en)) && (clk_out1_oe == $past(out1_en))));

  assert_oe_ignores_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_low && out0_en && out1_en) |=> (clk_out0_oe && clk_out1_oe));

  assert_out0_rise_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out0) |-> ($past(div_wrap[0]) || $past(force_low, 2)));

  assert_out1_rise_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out1) |-> ($past(div_wrap[0]) || $past(div_wrap[1]) || $past(force_low, 2)));

endmodule

bind dual_clkdiv dual_clkdiv_checker u_chk (
  .clk         (clk_src),
  .rst_n       (rst_n),
  .force_low   (force_low),
  .out0_en     (out0_en),
  .out1_en     (out1_en),
  .div_wrap    (div_wrap),
  .clk_out0    (clk_out0),
  .clk_out1    (clk_out1),
  .clk_out0_oe (clk_out0_oe),
  .clk_out1_oe (clk_out1_oe)
);

// File: tb/dual_clkdiv_bench.sv
module dual_clkdiv_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div0_ratio = 8'd4;
  logic [7:0] div1_ratio = 8'd6;
  logic       out1_src_sel = 1'b1;
  logic       force_low = 1'b0;
  logic       out0_en = 1'b1;
  logic       out1_en = 1'b1;
  logic       clk_out0, clk_out0_oe, clk_out1, clk_out1_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  string lab0  = "R1";
  string lab1  = "R1";
  string laboe = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clkdiv u_dual_clkdiv (
    .clk_src      (clk),
    .rst_n        (rst_n),
    .div0_ratio   (div0_ratio),
    .div1_ratio   (div1_ratio),
    .out1_src_sel (out1_src_sel),
    .force_low    (force_low),
    .out0_en      (out0_en),
    .out1_en      (out1_en),
    .clk_out0     (clk_out0),
    .clk_out0_oe  (clk_out0_oe),
    .clk_out1     (clk_out1),
    .clk_out1_oe  (clk_out1_oe)
  );

  // behavioural reference model
  int m_pos [2];
  int m_per [2];
  int m_rq  [2];
  bit m_w   [2];
  bit m_hi  [2];
  bit m_start = 1'b1;
  int m_sel   = 0;
  bit m_hold  = 1'b0;
  bit m_out0 = 1'b0, m_out1 = 1'b0, m_oe0 = 1'b0, m_oe1 = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_start = 1'b1;
      m_sel   = 0;
      m_hold  = 1'b0;
      m_out0  = 1'b0;
      m_out1  = 1'b0;
      m_oe0   = 1'b0;
      m_oe1   = 1'b0;
      for (int i = 0; i < 2; i++) begin
        m_pos[i] = 0;
        m_per[i] = 2;
      end
    end else begin
      m_rq[0] = int'(div0_ratio);
      m_rq[1] = int'(div1_ratio);
      for (int i = 0; i < 2; i++) begin
        m_w[i] = m_start || (m_pos[i] == m_per[i] - 1);
        if (m_w[i]) begin
          m_pos[i] = 0;
          m_per[i] = (m_rq[i] < 2) ? 2 : m_rq[i];
        end else begin
          m_pos[i] = m_pos[i] + 1;
        end
        m_hi[i] = m_pos[i] < (m_per[i] / 2);
      end
      if (m_hold) begin
        if (m_w[m_sel]) m_hold = 1'b0;
      end else if ((int'(out1_src_sel) != m_sel) && m_w[m_sel]) begin
        m_sel  = int'(out1_src_sel);
        m_hold = !m_w[m_sel];
      end
      m_out0  = m_hi[0] && !force_low;
      m_out1  = !m_hold && m_hi[m_sel] && !force_low;
      m_oe0   = out0_en;
      m_oe1   = out1_en;
      m_start = 1'b0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check({lab0, " clk_out0"}, clk_out0, m_out0);
      check({lab1, " clk_out1"}, clk_out1, m_out1);
      check({laboe, " clk_out0_oe"}, clk_out0_oe, m_oe0);
      check({laboe, " clk_out1_oe"}, clk_out1_oe, m_oe1);
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: first rising edge coincides after reset
    check("R5 first rise out0", clk_out0, 1'b1);
    check("R5 first rise out1", clk_out1, 1'b1);
    lab0 = "R2"; lab1 = "R2"; laboe = "R9";
    run(48);

    // R4: ratio change mid-period
    lab0 = "R4"; lab1 = "R4";
    run(2);
    div0_ratio = 8'd7;
    run(40);
    div1_ratio = 8'd3;
    run(40);

    // R3: ratio 1 and 0 act as 2
    lab0 = "R3";
    div0_ratio = 8'd1;
    run(20);
    div0_ratio = 8'd0;
    run(20);

    // R5: equal ratios from reset give identical outputs
    lab0 = "R1"; lab1 = "R1"; laboe = "R1";
    rst_n = 1'b0;
    div0_ratio = 8'd5;
    div1_ratio = 8'd5;
    out1_src_sel = 1'b1;
    run(2);
    rst_n = 1'b1;
    lab0 = "R5"; lab1 = "R5"; laboe = "R9";
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check("R5 out1 equals out0", clk_out1, clk_out0);
    end

    // R6 / R7: select switching
    lab0 = "R6"; lab1 = "R7";
    div1_ratio = 8'd9;
    run(20);
    for (int k = 0; k < 10; k++) begin
      out1_src_sel = ~out1_src_sel;
      run(7 + k);
    end
    div0_ratio = 8'd3;
    div1_ratio = 8'd7;
    for (int k = 0; k < 6; k++) begin
      out1_src_sel = ~out1_src_sel;
      run(13);
    end

    // R8: force low
    lab0 = "R8"; lab1 = "R8";
    force_low = 1'b1;
    run(2);
    check("R8 out0 forced", clk_out0, 1'b0);
    check("R8 out1 forced", clk_out1, 1'b0);
    run(13);
    force_low = 1'b0;
    run(20);

    // R9: enables
    laboe = "R9";
    out0_en = 1'b0; out1_en = 1'b1;
    run(10);
    out0_en = 1'b1; out1_en = 1'b0;
    run(10);
    out0_en = 1'b0; out1_en = 1'b0;
    run(10);

    // R10: force low leaves the output enables alone
    laboe = "R10";
    force_low = 1'b1;
    out0_en = 1'b1; out1_en = 1'b1;
    run(2);
    check("R10 oe0 under force", clk_out0_oe, 1'b1);
    check("R10 oe1 under force", clk_out1_oe, 1'b1);
    out0_en = 1'b0;
    run(2);
    check("R10 oe0 disabled under force", clk_out0_oe, 1'b0);
    run(6);
    force_low = 1'b0;
    run(10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule